// File: doc/BRIEF.md
# Coherent Two-Byte Position Latch Reader

This block connects a free-running position counter of 12 or 16 bits to a host data bus that is eight bits wide. A holding register tracks the counter on every rising clock edge. The host fetches the held value one byte at a time. It steers the byte choice with a select input and enables the bus with an active-low read strobe.

A position value is wider than the bus, so the block freezes its holding register for the whole of a two-byte read. The read fetches the upper byte first. The freeze starts on the clock edge that samples the upper-byte strobe. The register then keeps the value it captured before that edge. The freeze ends in two steps. First, a falling clock edge samples a lower-byte access. Second, a later rising edge samples the strobe released. A host that needs only eight bits keeps the select input high at all times. In that case the freeze is never engaged and the lower byte follows the counter from one clock to the next.

Top module: `qd_latch_reader`

## Requirements
- R1: While reset is asserted, `data_oe_o` is 0 and `data_o` is 0, the holding register is cleared and the freeze is released.
- R2: While not frozen, and outside the edge that starts a freeze, each rising edge loads `count_i` into the holding register, so the bus shows the count of the previous clock.
- R3: A rising edge with `oe_n_i`=0 and `sel_i`=0 engages the freeze. That edge does not load the register. The register then keeps its earlier value for both bytes of the read.
- R4: With `oe_n_i`=0, `sel_i`=0 puts held bits 15..8 on `data_o` and `sel_i`=1 puts held bits 7..0 on `data_o`.
- R5: When `CNT_W` is 12, bits 7..4 of the upper byte always read as 0.
- R6: While `oe_n_i`=1, `data_oe_o` is 0 and `data_o` is 0. While `oe_n_i`=0 and reset is not asserted, `data_oe_o` is 1.
- R7: With `sel_i` held at 1, the freeze never engages and the bus shows the low byte of the count from one clock earlier.
- R8: The freeze is released by a rising edge that sees `oe_n_i`=1 after an earlier falling edge has sampled `oe_n_i`=0 with `sel_i`=1 while frozen. The register loads again from the next rising edge.
- R9: If the strobe goes high without a lower-byte access, the freeze stays engaged until a lower-byte access occurs and the strobe is released after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge updates state, falling edge samples the lower-byte access |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Live position count |
| oe_n_i | input | 1 | Active-low read strobe |
| sel_i | input | 1 | Byte choice: 0 upper byte, 1 lower byte |
| data_o | output | 8 | Selected byte, 0 while not enabled |
| data_oe_o | output | 1 | Bus drive enable (1 = driven) |

## Verification
If the freeze flag is wrong, the result appears in the first cycle of the next read. A flag that fails to engage lets the lower byte come from a newer count than the upper byte. A flag that stays stuck holds a stale value across several later reads. If the release condition is wrong, the symptom shows one cycle after the strobe is released. The register must load on the rising edge that follows the release and not before it. The bench uses directed sequences to check those two edges exactly and runs mixed random reads against a reference model.

// File: rtl/qd_rd_pkg.sv
package qd_rd_pkg;

    localparam int BYTE_W = 8;
    localparam int WIDE_W = 16;

    typedef struct packed {
        logic frozen;
        logic armed;
    } frz_state_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WIDE_W-1:0] word,
                                                     input logic lower);
        return lower ? word[BYTE_W-1:0] : word[WIDE_W-1:BYTE_W];
    endfunction

endpackage

// File: rtl/qd_freeze_ctrl.sv
module qd_freeze_ctrl
    import qd_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n_i,
    input  logic sel_i,
    output logic frozen_o,
    output logic armed_o,
    output logic start_o
);

    // Falling-edge sample of a lower-byte access.
    logic lo_seen_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_seen_q <= 1'b0;
        end else begin
            lo_seen_q <= ~oe_n_i & sel_i;
        end
    end

    frz_state_t st_d, st_q;
    logic       start_c;

    always_comb begin
        st_d    = st_q;
        start_c = ~oe_n_i & ~sel_i & ~st_q.frozen;
        if (st_q.frozen && st_q.armed && oe_n_i) begin
            st_d.frozen = 1'b0;
            st_d.armed  = 1'b0;
        end else begin
            if (!oe_n_i && !sel_i) begin
                st_d.frozen = 1'b1;
            end
            if (st_q.frozen && lo_seen_q) begin
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frozen_o = st_q.frozen;
    assign armed_o  = st_q.armed;
    assign start_o  = start_c;

endmodule

// File: rtl/qd_hold_reg.sv
module qd_hold_reg
    import qd_rd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              load_i,
    output logic [WIDE_W-1:0] held_o
);

    logic [CNT_W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (load_i) begin
            pos_d = count_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    generate
        if (CNT_W < WIDE_W) begin : g_pad
            assign held_o = {{(WIDE_W-CNT_W){1'b0}}, pos_q};
        end else begin : g_full
            assign held_o = pos_q;
        end
    endgenerate

endmodule

// File: rtl/qd_byte_mux.sv
module qd_byte_mux
    import qd_rd_pkg::*;
(
    input  logic              rst_n,
    input  logic [WIDE_W-1:0] held_i,
    input  logic              oe_n_i,
    input  logic              sel_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              data_oe_o
);

    logic drive_c;

    always_comb begin
        drive_c = ~oe_n_i & rst_n;
        data_o  = drive_c ? pick_byte(held_i, sel_i) : '0;
    end

    assign data_oe_o = drive_c;

endmodule

// File: rtl/qd_latch_reader.sv
module qd_latch_reader
    import qd_rd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             oe_n_i,
    input  logic             sel_i,
    output logic [7:0]       data_o,
    output logic             data_oe_o
);

    logic              frozen_w;
    logic              armed_w;
    logic              start_w;
    logic              load_w;
    logic [WIDE_W-1:0] held_w;

    qd_freeze_ctrl u_frz (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n_i   (oe_n_i),
        .sel_i    (sel_i),
        .frozen_o (frozen_w),
        .armed_o  (armed_w),
        .start_o  (start_w)
    );

    assign load_w = ~frozen_w & ~start_w;

    qd_hold_reg #(.CNT_W(CNT_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (count_i),
        .load_i  (load_w),
        .held_o  (held_w)
    );

    qd_byte_mux u_mux (
        .rst_n     (rst_n),
        .held_i    (held_w),
        .oe_n_i    (oe_n_i),
        .sel_i     (sel_i),
        .data_o    (data_o),
        .data_oe_o (data_oe_o)
    );

endmodule

// File: rtl/qd_latch_reader_chk.sv
module qd_latch_reader_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_i,
    input logic             oe_n_i,
    input logic             sel_i,
    input logic [7:0]       data_o,
    input logic             data_oe_o,
    input logic             frozen,
    input logic             armed,
    input logic [15:0]      held
);

    initial begin
        a_width_r5: assert (CNT_W >= 9 && CNT_W <= 16);
    end

    p_bus_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> (!data_oe_o && data_o == 8'h00));

    p_bus_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_i |-> data_oe_o);

    p_engage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_i && !sel_i) |=> frozen);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen || (!oe_n_i && !sel_i)) |=> $stable(held));

    p_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && !(!oe_n_i && !sel_i)) |=> (held[CNT_W-1:0] == $past(count_i)));

    p_no_engage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && sel_i) |=> !frozen);

    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !armed) |=> frozen);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && armed && oe_n_i) |=> !frozen);

    generate
        if (CNT_W < 16) begin : g_zero
            p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (data_oe_o && !sel_i) |-> (data_o[7:CNT_W-8] == '0));
        end
    endgenerate

endmodule

bind qd_latch_reader qd_latch_reader_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_i   (count_i),
    .oe_n_i    (oe_n_i),
    .sel_i     (sel_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .frozen    (frozen_w),
    .armed     (armed_w),
    .held      (held_w)
);

// File: tb/tb_qd_latch_reader.sv
module tb_qd_latch_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'h0;
    logic        oe_n = 1'b1;
    logic        sel = 1'b1;
    logic [7:0]  d16, d12;
    logic        oe16, oe12;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    qd_latch_reader #(.CNT_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .oe_n_i(oe_n), .sel_i(sel),
        .data_o(d16), .data_oe_o(oe16));

    qd_latch_reader #(.CNT_W(12)) dut12 (
        .clk(clk), .rst_n(rst_n), .count_i(cnt[11:0]), .oe_n_i(oe_n), .sel_i(sel),
        .data_o(d12), .data_oe_o(oe12));

    // Reference model built from the requirements.
    logic [15:0] m_pos;
    logic        m_frz, m_arm, m_lo;

    always @(negedge clk or negedge rst_n)
        if (!rst_n) m_lo <= 1'b0;
        else        m_lo <= !oe_n && sel;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos <= 16'h0; m_frz <= 1'b0; m_arm <= 1'b0;
        end else begin
            if (!m_frz && !(!oe_n && !sel)) m_pos <= cnt;       // R2
            if (m_frz && m_arm && oe_n) begin                   // R8
                m_frz <= 1'b0; m_arm <= 1'b0;
            end else begin
                if (!oe_n && !sel) m_frz <= 1'b1;               // R3
                if (m_frz && m_lo) m_arm <= 1'b1;
            end
        end
    end

    function automatic logic [7:0] exp_byte(input logic [15:0] w, input logic o, input logic s);
        if (o) return 8'h00;
        return s ? w[7:0] : w[15:8];
    endfunction

    task automatic check(input string tag);
        logic [7:0] e16, e12;
        e16 = exp_byte(m_pos, oe_n, sel);
        e12 = exp_byte(m_pos & 16'h0FFF, oe_n, sel);
        checks++;
        if (d16 !== e16 || oe16 !== !oe_n || d12 !== e12 || oe12 !== !oe_n) begin
            fails++;
            $display("FAIL %s data=%h/%h exp=%h/%h oe=%b/%b exp=%b",
                     tag, d16, d12, e16, e12, oe16, oe12, !oe_n);
        end
    endtask

    task automatic expect_val(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [15:0] c, input logic o, input logic s, input string tag);
        @(posedge clk); #2;
        cnt = c; oe_n = o; sel = s;
        #15;
        check(tag);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        cnt = 16'hA5C3; oe_n = 1'b1; sel = 1'b1;
        #55;
        checks++;
        if (oe16 !== 1'b0 || d16 !== 8'h00 || oe12 !== 1'b0) begin
            fails++; $display("FAIL R1 oe=%b data=%h exp oe=0 data=00", oe16, d16);
        end
        oe_n = 1'b0; #1;
        expect_val("R1 bus held off in reset", {7'd0, oe16}, 8'h00);
        oe_n = 1'b1;
        @(posedge clk); #2; rst_n = 1'b1;

        // R6 and R2: strobe high then tracking
        cyc(16'h0101, 1, 1, "R6");
        cyc(16'h0202, 1, 0, "R6");
        cyc(16'h0303, 0, 1, "R2");
        expect_val("R2 shows previous count", d16, 8'h02);

        // R7: continuous single-byte mode
        for (int i = 0; i < 10; i++) begin
            cyc(16'h1000 + 16'(i * 37), 0, 1, "R7");
            if (i > 0) expect_val("R7 live low byte", d16, 8'((i - 1) * 37));
        end

        // R3, R4, R5, R8: coherent two-byte read
        cyc(16'h1234, 1, 1, "R2");
        cyc(16'h5678, 0, 0, "R4");
        expect_val("R4 upper byte", d16, 8'h12);
        expect_val("R5 upper nibble zero", d12, 8'h02);
        cyc(16'h9ABC, 0, 0, "R3");
        expect_val("R3 held upper", d16, 8'h12);
        cyc(16'hDEF0, 0, 1, "R3");
        expect_val("R3 held lower", d16, 8'h34);
        cyc(16'h1111, 1, 1, "R8");
        cyc(16'h2222, 0, 1, "R8");
        expect_val("R8 still held before release edge", d16, 8'h34);
        cyc(16'h3333, 0, 1, "R8");
        expect_val("R8 loads after release", d16, 8'h22);

        // R9: strobe released without lower-byte access
        cyc(16'h4444, 1, 1, "R9");
        cyc(16'h5555, 0, 0, "R9");
        cyc(16'h6666, 1, 1, "R9");
        cyc(16'h7777, 1, 1, "R9");
        cyc(16'h8888, 0, 1, "R9");
        expect_val("R9 freeze kept", d16, 8'h44);
        cyc(16'h9999, 1, 1, "R9");
        cyc(16'hAAAA, 1, 1, "R8");
        cyc(16'hBBBB, 0, 1, "R8");
        expect_val("R8 release after late access", d16, 8'hAA);

        // R5 with a full-width value
        cyc(16'hFABC, 1, 1, "R5");
        cyc(16'h0000, 0, 0, "R5");
        expect_val("R5 twelve-bit upper", d12, 8'h0A);
        expect_val("R4 sixteen-bit upper", d16, 8'hFA);
        cyc(16'h0000, 0, 1, "R5");
        cyc(16'h0000, 1, 1, "R5");

        // Random mixed traffic checked against the model
        for (int t = 0; t < 400; t++) begin
            int kind;
            kind = int'($urandom_range(0, 3));
            for (int k = 0; k < int'($urandom_range(1, 3)); k++)
                cyc(cnt + 16'($urandom_range(0, 300)), 1, 1'($urandom), "R2");
            case (kind)
                0, 1: begin
                    for (int k = 0; k < int'($urandom_range(1, 2)); k++)
                        cyc(cnt + 16'($urandom_range(0, 300)), 0, 0, "R3");
                    for (int k = 0; k < int'($urandom_range(1, 2)); k++)
                        cyc(cnt + 16'($urandom_range(0, 300)), 0, 1, "R3");
                    cyc(cnt + 16'($urandom_range(0, 300)), 1, 1, "R8");
                end
                2: begin
                    cyc(cnt + 16'($urandom_range(0, 300)), 0, 0, "R9");
                    cyc(cnt + 16'($urandom_range(0, 300)), 1, 0, "R9");
                end
                default: begin
                    for (int k = 0; k < 4; k++)
                        cyc(cnt + 16'($urandom_range(0, 300)), 0, 1, "R7");
                end
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule